// File: doc/BRIEF.md
# Stream Write Receive Controller

This block is the card-side controller for an open-length stream write. A start command carries a byte address. The controller checks that the bus is in a legal configuration for streaming and that the address is usable. It then places each incoming byte into a single-entry holding register at a rising address. The programming side drains that register through a ready handshake. No length and no CRC are involved: only a stop command ends the transfer.

While receiving, three faults can end useful work. The first is a byte arriving after the last memory address. The second is a byte arriving while the holding register is still full, which is an overrun. The third is a byte aimed at a write-protected group. After any fault the controller discards every further byte and keeps the fault flag. The stop command then reports the flag and returns the controller to the transfer state. Every command receives a status word on the cycle after it is presented.

The controller has three states: TRANSFER (`ST_TRAN`, idle), RECEIVE (`ST_RECV`, accepting bytes) and DISCARD (`ST_DISCARD`, faulted and waiting for stop). It has three transitions: *accept* (TRANSFER to RECEIVE on a clean start), *fault* (RECEIVE to DISCARD on a bad byte) and *stop* (RECEIVE or DISCARD to TRANSFER).

Top module: `swr_stream_ctrl`

## Requirements
- R1: A start command (`cmd_op`=1) presented while `bus_1bit`=0 or `bus_ddr`=1 is refused. Its status is exactly 8'h01 (illegal flag, bit 0), and the controller stays in TRANSFER.
- R2: When the bus is legal, a start argument at or above `MEM_BYTES` sets the range flag (bit 1) and refuses the start. All `ARG_W` argument bits take part in this comparison.
- R3: If `partial_ok` is 0 when a start is presented, an argument whose low `BLK_W` bits are nonzero sets the align flag (bit 2) and refuses the start. A stop received in RECEIVE while the next address is not block-aligned also sets bit 2. The `partial_ok` value used for the stop check is the one captured at the start.
- R4: A start with no flag is accepted and answered with 8'h20 (receive bit 5). Each byte then appears on `mem_wr_*` one cycle after it is presented, at consecutive addresses beginning at the argument. Address and data hold steady until `mem_ready` is seen high.
- R5: A byte that arrives when the next address equals `MEM_BYTES` is not written, and it moves the controller to DISCARD. The following stop reports bit 1. Writing up to and including the last address and then stopping reports 8'h00.
- R6: A byte that arrives while the holding register is full and `mem_ready` is low is an overrun. It also empties the holding register, moves the controller to DISCARD, and the stop reports bit 3.
- R7: A byte whose address falls in a group with its `wp_map` bit set is not written. It moves the controller to DISCARD, and the stop reports bit 4. A group spans 2^`WPG_W` bytes, and bit g of `wp_map` covers group g.
- R8: In DISCARD no byte reaches `mem_wr_*`. Fault flags stay set until the stop response that reports them. After that stop the controller is back in TRANSFER with the flags cleared.
- R9: The following are answered with 8'h01 and change nothing: a stop in TRANSFER, a start outside TRANSFER, and any `cmd_op` other than 1 (start) or 2 (stop). Bytes presented in TRANSFER are ignored.
- R10: Every cycle with `cmd_valid` high produces `rsp_valid` high on the next cycle, and `rsp_valid` is never high at any other time. If a command and a byte arrive in the same cycle, the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 1 = start, 2 = stop, other values illegal |
| cmd_arg | input | ARG_W | Start byte address |
| bus_1bit | input | 1 | Bus is one data line wide |
| bus_ddr | input | 1 | Bus runs at dual data rate |
| partial_ok | input | 1 | Unaligned start and stop permitted |
| wp_map | input | WP_GROUPS | Write-protect bit per address group |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| mem_wr_valid | output | 1 | Holding register full |
| mem_wr_addr | output | ADDR_W | Address of held byte |
| mem_wr_data | output | 8 | Held byte |
| mem_ready | input | 1 | Programming side takes the held byte |
| rsp_valid | output | 1 | Status word valid |
| rsp_status | output | 8 | Bit0 illegal, 1 range, 2 align, 3 overrun, 4 protect, 5 receiving |

## Verification
A wrong state register shows up at the ports within one or two cycles. A controller stuck in RECEIVE after a fault keeps emitting writes. A missed transition to RECEIVE turns the next stop into an illegal response. A corrupt address counter shows on the first `mem_wr_addr` after the error. A lost sticky flag stays hidden until the stop response, so the bench always follows a fault with a stop and compares the whole status word. Alignment at stop and flag clearing are checked through the second command after a fault.

// File: rtl/swr_pkg.sv
package swr_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_START = 2'd1,
        OP_STOP  = 2'd2,
        OP_RSVD  = 2'd3
    } swr_op_e;

    typedef enum logic [1:0] {
        ST_TRAN    = 2'd0,
        ST_RECV    = 2'd1,
        ST_DISCARD = 2'd2
    } swr_state_e;

    localparam int unsigned STS_W  = 8;
    localparam int unsigned B_RECV = 5;

    // packed from MSB: protect=bit4 ... illegal=bit0
    typedef struct packed {
        logic protect;
        logic overrun;
        logic align;
        logic range;
        logic illegal;
    } swr_err_t;

endpackage

// File: rtl/swr_cmd_check.sv
module swr_cmd_check
    import swr_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 1000,
    parameter int unsigned BLK_W     = 4,
    parameter int unsigned ARG_W     = 32
) (
    input  logic [ARG_W-1:0] arg,
    input  logic             bus_1bit,
    input  logic             bus_ddr,
    input  logic             partial_ok,
    output swr_err_t         verdict
);

    logic unaligned;

    generate
        if (BLK_W > 0) begin : g_align
            assign unaligned = |arg[BLK_W-1:0];
        end else begin : g_noalign
            assign unaligned = 1'b0;
        end
    endgenerate

    always_comb begin
        verdict = '0;
        if (!bus_1bit || bus_ddr) begin
            verdict.illegal = 1'b1;
        end else begin
            verdict.range = (arg >= ARG_W'(MEM_BYTES));
            verdict.align = !partial_ok && unaligned;
        end
    end

endmodule

// File: rtl/swr_wp_lookup.sv
module swr_wp_lookup #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned WPG_W     = 7,
    parameter int unsigned WP_GROUPS = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WP_GROUPS-1:0] wp_map,
    output logic                 hit
);

    logic [ADDR_W-1:0]    grp;
    logic [WP_GROUPS-1:0] match;

    assign grp = addr >> WPG_W;

    generate
        for (genvar g = 0; g < WP_GROUPS; g++) begin : g_grp
            assign match[g] = wp_map[g] && (grp == ADDR_W'(g));
        end
    endgenerate

    assign hit = |match;

endmodule

// File: rtl/swr_hold_buf.sv
module swr_hold_buf #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              flush,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              ready,
    output logic              full,
    output logic [ADDR_W-1:0] out_addr,
    output logic [7:0]        out_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            out_addr <= '0;
            out_data <= '0;
        end else if (load) begin
            full     <= 1'b1;
            out_addr <= ld_addr;
            out_data <= ld_data;
        end else if (flush) begin
            full <= 1'b0;
        end else if (full && ready) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/swr_stream_ctrl.sv
module swr_stream_ctrl
    import swr_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 1000,
    parameter int unsigned BLK_W     = 4,
    parameter int unsigned WPG_W     = 7,
    parameter int unsigned ARG_W     = 32,
    localparam int unsigned ADDR_W    = $clog2(MEM_BYTES + 1),
    localparam int unsigned WP_GROUPS = (MEM_BYTES + (1 << WPG_W) - 1) >> WPG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [ARG_W-1:0]     cmd_arg,
    input  logic                 bus_1bit,
    input  logic                 bus_ddr,
    input  logic                 partial_ok,
    input  logic [WP_GROUPS-1:0] wp_map,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    output logic                 mem_wr_valid,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [7:0]           mem_wr_data,
    input  logic                 mem_ready,
    output logic                 rsp_valid,
    output logic [STS_W-1:0]     rsp_status
);

    swr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              partial_q;
    swr_err_t          err_q;
    swr_err_t          chk_err;
    swr_op_e           op;
    logic              wp_hit, hold_full;
    logic              is_start, is_stop, start_ok, byte_take, at_end;
    logic              fault_range, fault_wp, fault_ovr, load;
    logic              stop_unaligned;
    logic [STS_W-1:0]  rsp_d;

    assign op        = swr_op_e'(cmd_op);
    assign is_start  = cmd_valid && (op == OP_START);
    assign is_stop   = cmd_valid && (op == OP_STOP);
    assign start_ok  = is_start && (state_q == ST_TRAN) && (chk_err == '0);
    assign byte_take = byte_valid && !cmd_valid && (state_q == ST_RECV);
    assign at_end    = (addr_q == ADDR_W'(MEM_BYTES));

    assign fault_range = byte_take && at_end;
    assign fault_wp    = byte_take && !at_end && wp_hit;
    assign fault_ovr   = byte_take && !at_end && !wp_hit && hold_full && !mem_ready;
    assign load        = byte_take && !at_end && !wp_hit && !(hold_full && !mem_ready);

    generate
        if (BLK_W > 0) begin : g_stop_align
            assign stop_unaligned = !partial_q && (|addr_q[BLK_W-1:0]);
        end else begin : g_stop_free
            assign stop_unaligned = 1'b0;
        end
    endgenerate

    swr_cmd_check #(
        .MEM_BYTES (MEM_BYTES),
        .BLK_W     (BLK_W),
        .ARG_W     (ARG_W)
    ) u_cmd_check (
        .arg        (cmd_arg),
        .bus_1bit   (bus_1bit),
        .bus_ddr    (bus_ddr),
        .partial_ok (partial_ok),
        .verdict    (chk_err)
    );

    swr_wp_lookup #(
        .ADDR_W    (ADDR_W),
        .WPG_W     (WPG_W),
        .WP_GROUPS (WP_GROUPS)
    ) u_wp_lookup (
        .addr   (addr_q),
        .wp_map (wp_map),
        .hit    (wp_hit)
    );

    swr_hold_buf #(
        .ADDR_W (ADDR_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .flush    (fault_ovr),
        .ld_addr  (addr_q),
        .ld_data  (byte_data),
        .ready    (mem_ready),
        .full     (hold_full),
        .out_addr (mem_wr_addr),
        .out_data (mem_wr_data)
    );

    assign mem_wr_valid = hold_full;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRAN: begin
                if (start_ok) state_d = ST_RECV;
            end
            ST_RECV: begin
                if (is_stop)
                    state_d = ST_TRAN;
                else if (fault_range || fault_wp || fault_ovr)
                    state_d = ST_DISCARD;
            end
            ST_DISCARD: begin
                if (is_stop) state_d = ST_TRAN;
            end
            default: state_d = ST_TRAN;
        endcase
    end

    // response word
    always_comb begin
        rsp_d = '0;
        if (cmd_valid) begin
            unique case (op)
                OP_START: begin
                    if (state_q != ST_TRAN) begin
                        rsp_d[0] = 1'b1;
                    end else begin
                        rsp_d[4:0]    = chk_err;
                        rsp_d[B_RECV] = (chk_err == '0);
                    end
                end
                OP_STOP: begin
                    if (state_q == ST_TRAN) begin
                        rsp_d[0] = 1'b1;
                    end else begin
                        rsp_d[4:0] = err_q;
                        if (state_q == ST_RECV && stop_unaligned) rsp_d[2] = 1'b1;
                    end
                end
                default: rsp_d[0] = 1'b1;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRAN;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
            addr_q     <= '0;
            partial_q  <= 1'b0;
            err_q      <= '0;
        end else begin
            rsp_valid  <= cmd_valid;
            rsp_status <= rsp_d;
            if (start_ok) begin
                addr_q    <= cmd_arg[ADDR_W-1:0];
                partial_q <= partial_ok;
                err_q     <= '0;
            end else if (is_stop && state_q != ST_TRAN) begin
                err_q <= '0;
            end else begin
                if (fault_range) err_q.range   <= 1'b1;
                if (fault_wp)    err_q.protect <= 1'b1;
                if (fault_ovr)   err_q.overrun <= 1'b1;
                if (load)        addr_q        <= addr_q + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/swr_stream_ctrl_chk.sv
module swr_stream_ctrl_chk #(
    parameter int unsigned MEM_BYTES = 1000,
    parameter int unsigned WPG_W     = 7,
    localparam int unsigned ADDR_W    = $clog2(MEM_BYTES + 1),
    localparam int unsigned WP_GROUPS = (MEM_BYTES + (1 << WPG_W) - 1) >> WPG_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 rsp_valid,
    input logic [7:0]           rsp_status,
    input logic                 mem_wr_valid,
    input logic [ADDR_W-1:0]    mem_wr_addr,
    input logic [7:0]           mem_wr_data,
    input logic                 mem_ready,
    input logic [WP_GROUPS-1:0] wp_map,
    input logic [1:0]           state_q,
    input logic [4:0]           err_q
);

    logic [WP_GROUPS-1:0] wp_prev_q;
    logic [ADDR_W-1:0]    grp;

    always_ff @(posedge clk) wp_prev_q <= wp_map;
    assign grp = mem_wr_addr >> WPG_W;

    p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_ready |=>
            !mem_wr_valid || ($stable(mem_wr_addr) && $stable(mem_wr_data)));

    p_accept_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status[5] |-> rsp_status[4:0] == 5'd0);

    p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_addr < ADDR_W'(MEM_BYTES));

    p_wr_unprot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !$past(mem_wr_valid) |-> !((wp_prev_q >> grp) & 1));

    p_discard_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == 2'd2 |-> $countones(err_q) > 0);

    p_illegal_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status[0] |-> rsp_status[5:1] == 5'd0);

endmodule

bind swr_stream_ctrl swr_stream_ctrl_chk #(
    .MEM_BYTES (MEM_BYTES),
    .WPG_W     (WPG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_ready    (mem_ready),
    .wp_map       (wp_map),
    .state_q      (state_q),
    .err_q        (err_q)
);

// File: tb/swr_stream_ctrl_tb_top.sv
module swr_stream_ctrl_tb_top;

    localparam int CLK_P  = 10;
    localparam int MEM    = 1000;
    localparam int ADDR_W = 10;
    localparam int WPG    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [31:0]       cmd_arg = '0;
    logic              bus_1bit = 1'b1;
    logic              bus_ddr = 1'b0;
    logic              partial_ok = 1'b1;
    logic [WPG-1:0]    wp_map = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              mem_wr_valid;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [7:0]        mem_wr_data;
    logic              mem_ready = 1'b1;
    logic              rsp_valid;
    logic [7:0]        rsp_status;

    swr_stream_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .bus_1bit(bus_1bit), .bus_ddr(bus_ddr),
        .partial_ok(partial_ok), .wp_map(wp_map), .byte_valid(byte_valid),
        .byte_data(byte_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_ready(mem_ready), .rsp_valid(rsp_valid), .rsp_status(rsp_status)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    string cur = "R4";

    // expected-behaviour model state: 0 transfer, 1 receive, 2 discard
    int       m_state = 0;
    int       m_addr = 0;
    bit       m_part = 0;
    bit [4:0] m_err = 0;
    bit       m_full = 0;
    int       m_haddr = 0;
    bit [7:0] m_hdata = 0;
    bit       m_rv = 0;
    bit [7:0] m_rs = 0;

    task automatic chk(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic string lab(bit [7:0] s);
        if (s[0]) return "R1/R9";
        if (s[4]) return "R7";
        if (s[3]) return "R6";
        if (s[1]) return "R2/R5";
        if (s[2]) return "R3";
        if (s[5]) return "R4";
        return "R8";
    endfunction

    task automatic model_edge();
        bit drain = m_full && mem_ready;
        bit ld = 0;
        bit fl = 0;
        m_rv = cmd_valid;
        m_rs = 0;
        if (cmd_valid) begin
            if (cmd_op == 2'd1) begin
                if (m_state != 0 || !bus_1bit || bus_ddr) m_rs = 8'h01;
                else begin
                    if (cmd_arg >= 32'(MEM)) m_rs[1] = 1;
                    if (!partial_ok && cmd_arg[3:0] != 0) m_rs[2] = 1;
                    if (m_rs == 0) begin
                        m_rs = 8'h20; m_state = 1; m_addr = int'(cmd_arg);
                        m_part = partial_ok; m_err = 0;
                    end
                end
            end else if (cmd_op == 2'd2) begin
                if (m_state == 0) m_rs = 8'h01;
                else begin
                    m_rs = {3'b000, m_err};
                    if (m_state == 1 && !m_part && (m_addr % 16) != 0) m_rs[2] = 1;
                    m_state = 0; m_err = 0;
                end
            end else m_rs = 8'h01;
        end else if (byte_valid && m_state == 1) begin
            if (m_addr == MEM) begin m_err[1] = 1; m_state = 2; end
            else if (wp_map[m_addr / 128]) begin m_err[4] = 1; m_state = 2; end
            else if (m_full && !mem_ready) begin m_err[3] = 1; m_state = 2; fl = 1; end
            else begin ld = 1; m_haddr = m_addr; m_hdata = byte_data; m_addr++; end
        end
        if (ld) m_full = 1;
        else if (fl || drain) m_full = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R10", int'(rsp_valid), int'(m_rv));
        if (m_rv) chk(lab(m_rs), int'(rsp_status), int'(m_rs));
        chk(cur, int'(mem_wr_valid), int'(m_full));
        if (m_full) begin
            chk(cur, int'(mem_wr_addr), m_haddr);
            chk(cur, int'(mem_wr_data), int'(m_hdata));
        end
    endtask

    task automatic do_cmd(int op, int arg);
        cmd_valid = 1; cmd_op = 2'(op); cmd_arg = 32'(arg);
        step();
        cmd_valid = 0; cmd_op = 0;
    endtask

    task automatic do_bytes(int n);
        for (int k = 0; k < n; k++) begin
            byte_valid = 1; byte_data = 8'($urandom);
            step();
        end
        byte_valid = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R10", int'(rsp_valid), 0);
        chk("R4", int'(mem_wr_valid), 0);

        // R1: bus configuration
        cur = "R1"; bus_1bit = 0; do_cmd(1, 0); chk("R1", int'(rsp_status), 8'h01);
        bus_1bit = 1; bus_ddr = 1; do_cmd(1, 0); chk("R1", int'(rsp_status), 8'h01);
        bus_ddr = 0;
        // R2: range
        cur = "R2"; do_cmd(1, MEM); chk("R2", int'(rsp_status), 8'h02);
        do_cmd(1, 32'hFFFF_0000); chk("R2", int'(rsp_status), 8'h02);
        // R3: alignment
        cur = "R3"; partial_ok = 0; do_cmd(1, 5); chk("R3", int'(rsp_status), 8'h04);
        partial_ok = 1; do_cmd(1, 5); chk("R4", int'(rsp_status), 8'h20);
        do_bytes(3); step(); do_cmd(2, 0); chk("R3", int'(rsp_status), 8'h00);
        partial_ok = 0; do_cmd(1, 16); do_bytes(3); do_cmd(2, 0);
        chk("R3", int'(rsp_status), 8'h04);
        do_cmd(1, 32); do_bytes(16); do_cmd(2, 0); chk("R3", int'(rsp_status), 8'h00);
        partial_ok = 1;
        // R9: sequencing
        cur = "R9"; do_cmd(2, 0); chk("R9", int'(rsp_status), 8'h01);
        do_bytes(2); chk("R9", int'(mem_wr_valid), 0);
        do_cmd(1, 200); do_cmd(1, 300); chk("R9", int'(rsp_status), 8'h01);
        do_cmd(3, 0); chk("R9", int'(rsp_status), 8'h01);
        do_bytes(1); chk("R9", int'(mem_wr_addr), 200);
        // R10: command beats byte
        cur = "R10"; byte_valid = 1; do_cmd(2, 0); byte_valid = 0;
        chk("R10", int'(rsp_status), 8'h00); step(); chk("R10", int'(mem_wr_valid), 0);
        // R5: end of range
        cur = "R5"; do_cmd(1, MEM - 2); do_bytes(2); do_cmd(2, 0);
        chk("R5", int'(rsp_status), 8'h00);
        do_cmd(1, MEM - 2); do_bytes(3); step(); do_cmd(2, 0);
        chk("R5", int'(rsp_status), 8'h02);
        // R6: overrun
        cur = "R6"; mem_ready = 0; do_cmd(1, 64); do_bytes(2);
        chk("R6", int'(mem_wr_valid), 0);
        mem_ready = 1; do_bytes(4); chk("R8", int'(mem_wr_valid), 0);
        do_cmd(2, 0); chk("R6", int'(rsp_status), 8'h08);
        // R7 / R8: protect, sticky, clear
        cur = "R7"; wp_map = 8'b0000_0010; do_cmd(1, 124); do_bytes(6); step();
        do_cmd(2, 0); chk("R7", int'(rsp_status), 8'h10);
        cur = "R8"; do_cmd(2, 0); chk("R8", int'(rsp_status), 8'h01);
        do_cmd(1, 400); chk("R8", int'(rsp_status), 8'h20);
        do_cmd(2, 0); chk("R8", int'(rsp_status), 8'h00);
        wp_map = 0;

        // random mix
        cur = "R4";
        begin
            bit slow = 0;
            for (int i = 0; i < 4000; i++) begin
                int r;
                int a;
                cmd_valid = 0; cmd_op = 0;
                if (i % 300 == 0) slow = ($urandom % 3 == 0);
                mem_ready  = slow ? ($urandom % 3 == 0) : ($urandom % 16 != 0);
                byte_valid = ($urandom % 5 < 3);
                byte_data  = 8'($urandom);
                if (m_state == 0 && $urandom % 8 == 0)
                    wp_map = 8'($urandom & $urandom & $urandom);
                if ($urandom % 25 == 0) begin
                    cmd_valid = 1;
                    r = int'($urandom % 16);
                    cmd_op = (r < 8) ? 2'd1 : ((r < 15) ? 2'd2 : 2'd3);
                    bus_1bit   = ($urandom % 10 != 0);
                    bus_ddr    = ($urandom % 12 == 0);
                    partial_ok = $urandom % 2;
                    a = int'($urandom % (MEM + 40));
                    if ($urandom % 2) a = a & ~15;
                    if ($urandom % 6 == 0) a = MEM - 1 - int'($urandom % 24);
                    cmd_arg = 32'(a);
                end
                step();
            end
        end
        cmd_valid = 0; byte_valid = 0;
        finish_run();
    end

endmodule